// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog that sits behind a byte-wide register bus inside a 16-byte local window. Software programs a 6-bit reload count (one count per tick of a slow time base, nominally 0.6 s), then keeps the system alive by writing a key value to a reload register. The `tickEn` input is a one-cycle strobe from an external prescaler and stands in for the real time base. A timeout of N seconds corresponds to a count of N*10/6.

Expiry happens in two stages. The first time the counter runs out, the block sets a first-timeout status flag and raises an interrupt request if interrupts are enabled. It then reloads the counter and starts over. If the counter runs out again before software writes the reload key, the block sets a sticky second-timeout flag and pulses a system-reset request, if reboot is enabled. The second-timeout flag is cleared only by power-on reset or by software. It survives the system reset that the watchdog itself requests, so that software can tell after reboot that the watchdog caused the reset.

There are two reset inputs. The power-on reset clears everything. The system reset clears everything except the second-timeout flag.

Top module: `wdog_two_stage`

## Requirements
- R1: After either reset, the register bytes read as follows: offset 0x00 (live count) = 50, offset 0x01 (timer value) = 0x32, offset 0x04 (status) = 0, offset 0x08 = 0, offset 0x09 = 0x08 (halt set). Both `smiReq` and `sysRstReq` are low.
- R2: Writing exactly 0x01 to offset 0x00 loads the counter from timer-value bits [5:0]. Any other value written to offset 0x00 has no effect. A read of offset 0x00 returns the live count in bits [5:0].
- R3: A write to offset 0x01 always stores data bits [7:6]. It updates bits [5:0] only when the written count is 4 or more. A written count of 0 to 3 leaves the previous count in place.
- R4: Offset 0x09 bit 3 is the halt bit, which is control-word bit 11. While halt is set the counter holds. While halt is clear the counter drops by one on each `tickEn`.
- R5: On a tick with the count at 1, and with no second stage pending, the block does three things: it sets status bit 0, it reloads the count, and it arms the second stage. `smiReq` is high whenever status bit 0 and the interrupt enable (offset 0x08 bit 0) are both set. The live count never reads 0.
- R6: On a tick with the count at 1 and the second stage armed, the block sets status bit 1 and reloads the count. It drives `sysRstReq` high for exactly one cycle, but only if reboot enable (offset 0x08 bit 1) is set. With reboot enable clear, no reset request is produced.
- R7: The status bits are write-one-to-clear at offset 0x04: bit 0 is the first timeout and bit 1 is the second timeout. A bit that is set by an expiry in the same cycle stays set.
- R8: Status bit 1 is unaffected by `rstSysN` and is cleared by `rstPorN`. `rstSysN` restores every other R1 value.
- R9: A reload-key write disarms the second stage, so the next expiry is again a first-stage expiry. It also takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPorN | input | 1 | Power-on reset, synchronous, active low; clears all state |
| rstSysN | input | 1 | System reset, synchronous, active low; keeps the second-timeout flag |
| tickEn | input | 1 | One-cycle time-base tick from a prescaler |
| busWrEn | input | 1 | Byte write strobe |
| busAddr | input | 4 | Local byte offset |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| smiReq | output | 1 | Interrupt request: first timeout and interrupt enable |
| sysRstReq | output | 1 | One-cycle system-reset request on a second timeout |

## Verification
Read data follows `busAddr` combinationally, within the same cycle. A write becomes visible in the read data and in the outputs just after the rising edge that samples it. An expiry updates status, count and `smiReq` on the edge that samples the final tick. `sysRstReq` is high for exactly the cycle that follows that edge.

The bench holds a behavioural model that steps on every rising edge, using the same sampled inputs as the design. It compares read data and both requests 4 ns after each edge, so every result is checked in the cycle it is due. Directed reads are taken at mid-cycle after each stimulus.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W    = 6;
  localparam int ADDR_W   = 4;
  localparam int BYTE_W   = 8;
  localparam int MIN_LOAD = 4;
  localparam int DEF_LOAD = 50;
  localparam int HALT_BIT = 3;  // control word bit 11 lands in byte 0x09 bit 3
  localparam int SMI_BIT  = 0;
  localparam int BOOT_BIT = 1;
  localparam int ST_FIRST = 0;
  localparam int ST_SECOND = 1;

  localparam logic [ADDR_W-1:0] OFS_RELOAD = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_TMRVAL = 4'h1;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTL_LO = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_CTL_HI = 4'h9;
  localparam logic [BYTE_W-1:0] RELOAD_KEY = 8'h01;

  typedef struct packed {
    logic             reload;
    logic             run;
    logic             clrFirst;
    logic             clrSecond;
    logic             rebootEn;
    logic [CNT_W-1:0] loadVal;
  } wdogStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstAnyN,
  input  logic              tickEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              firstTo,
  input  logic              secondTo,
  output wdogStrobe_t       strb,
  output logic [BYTE_W-1:0] busRdData,
  output logic              smiReq
);
  localparam int UP_W = BYTE_W - CNT_W;

  logic [BYTE_W-1:0] tmrVal;
  logic              smiEn;
  logic              rebootEn;
  logic              halt;
  logic              wrTmr;
  logic              wrStat;
  logic              wrCtlLo;
  logic              wrCtlHi;
  logic              countOk;

  assign wrTmr   = rstAnyN && busWrEn && (busAddr == OFS_TMRVAL);
  assign wrStat  = rstAnyN && busWrEn && (busAddr == OFS_STAT);
  assign wrCtlLo = rstAnyN && busWrEn && (busAddr == OFS_CTL_LO);
  assign wrCtlHi = rstAnyN && busWrEn && (busAddr == OFS_CTL_HI);
  assign countOk = (busWrData[CNT_W-1:0] >= CNT_W'(MIN_LOAD));

  always_ff @(posedge clk) begin
    if (!rstAnyN) begin
      tmrVal   <= BYTE_W'(DEF_LOAD);
      smiEn    <= 1'b0;
      rebootEn <= 1'b0;
      halt     <= 1'b1;
    end else begin
      if (wrTmr) begin
        tmrVal[BYTE_W-1:CNT_W] <= busWrData[BYTE_W-1:CNT_W];
        if (countOk) tmrVal[CNT_W-1:0] <= busWrData[CNT_W-1:0];
      end
      if (wrCtlLo) begin
        smiEn    <= busWrData[SMI_BIT];
        rebootEn <= busWrData[BOOT_BIT];
      end
      if (wrCtlHi) halt <= busWrData[HALT_BIT];
    end
  end

  always_comb begin
    strb           = '0;
    strb.reload    = rstAnyN && busWrEn && (busAddr == OFS_RELOAD) && (busWrData == RELOAD_KEY);
    strb.run       = rstAnyN && !halt && tickEn;
    strb.clrFirst  = wrStat && busWrData[ST_FIRST];
    strb.clrSecond = wrStat && busWrData[ST_SECOND];
    strb.rebootEn  = rebootEn;
    strb.loadVal   = tmrVal[CNT_W-1:0];
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_RELOAD: busRdData = {{UP_W{1'b0}}, cnt};
      OFS_TMRVAL: busRdData = tmrVal;
      OFS_STAT: begin
        busRdData[ST_FIRST]  = firstTo;
        busRdData[ST_SECOND] = secondTo;
      end
      OFS_CTL_LO: begin
        busRdData[SMI_BIT]  = smiEn;
        busRdData[BOOT_BIT] = rebootEn;
      end
      OFS_CTL_HI: busRdData[HALT_BIT] = halt;
      default:    busRdData = '0;
    endcase
  end

  assign smiReq = smiEn && firstTo;

  // R3: a too-small count leaves the stored count alone
  p_small_ignored_r3: assert property (@(posedge clk) disable iff (!rstAnyN)
    (wrTmr && !countOk) |=> (tmrVal[CNT_W-1:0] == $past(tmrVal[CNT_W-1:0])));

  // R3: the stored count never drops below the legal minimum
  p_count_legal_r3: assert property (@(posedge clk) disable iff (!rstAnyN)
    tmrVal[CNT_W-1:0] >= CNT_W'(MIN_LOAD));
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstPorN,
  input  logic             rstAnyN,
  input  wdogStrobe_t      strb,
  output logic [CNT_W-1:0] cnt,
  output logic             firstTo,
  output logic             secondTo,
  output logic             rstPulse
);
  logic armed;
  logic atEnd;
  logic firstExp;
  logic secondExp;

  assign atEnd     = (cnt <= CNT_W'(1));
  assign firstExp  = rstAnyN && strb.run && !strb.reload && atEnd && !armed;
  assign secondExp = rstAnyN && strb.run && !strb.reload && atEnd && armed;

  always_ff @(posedge clk) begin
    if (!rstAnyN) begin
      cnt      <= CNT_W'(DEF_LOAD);
      armed    <= 1'b0;
      firstTo  <= 1'b0;
      rstPulse <= 1'b0;
    end else begin
      rstPulse <= secondExp && strb.rebootEn;
      if (strb.reload) begin
        cnt   <= strb.loadVal;
        armed <= 1'b0;
      end else if (strb.run) begin
        if (atEnd) begin
          cnt   <= strb.loadVal;
          armed <= !armed;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
      if (firstExp)           firstTo <= 1'b1;
      else if (strb.clrFirst) firstTo <= 1'b0;
    end
  end

  // second-stage flag lives on power-on reset only
  always_ff @(posedge clk) begin
    if (!rstPorN)            secondTo <= 1'b0;
    else if (secondExp)      secondTo <= 1'b1;
    else if (strb.clrSecond) secondTo <= 1'b0;
  end

  // R4: no tick and no reload keeps the count
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rstAnyN)
    (!strb.run && !strb.reload) |=> $stable(cnt));

  // R2: a key write loads the programmed count
  p_reload_r2: assert property (@(posedge clk) disable iff (!rstAnyN)
    strb.reload |=> (cnt == $past(strb.loadVal)));

  // R5: the live count never reaches zero
  p_nonzero_r5: assert property (@(posedge clk) disable iff (!rstAnyN)
    cnt != '0);

  // R6: reset request only with reboot enabled and the second flag up
  p_pulse_gated_r6: assert property (@(posedge clk) disable iff (!rstAnyN)
    rstPulse |-> (secondTo && $past(strb.rebootEn)));

  // R6: the reset request lasts one cycle
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rstAnyN)
    rstPulse |=> !rstPulse);

  // R8: second flag holds unless cleared by software
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstPorN)
    (secondTo && !strb.clrSecond) |=> secondTo);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              rstSysN,
  input  logic              tickEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  output logic              smiReq,
  output logic              sysRstReq
);
  logic             rstAnyN;
  wdogStrobe_t      strb;
  logic [CNT_W-1:0] cnt;
  logic             firstTo;
  logic             secondTo;

  assign rstAnyN = rstPorN && rstSysN;

  wdog_ctrl u_ctrl (
    .clk       (clk),
    .rstAnyN   (rstAnyN),
    .tickEn    (tickEn),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .cnt       (cnt),
    .firstTo   (firstTo),
    .secondTo  (secondTo),
    .strb      (strb),
    .busRdData (busRdData),
    .smiReq    (smiReq)
  );

  wdog_datapath u_dp (
    .clk      (clk),
    .rstPorN  (rstPorN),
    .rstAnyN  (rstAnyN),
    .strb     (strb),
    .cnt      (cnt),
    .firstTo  (firstTo),
    .secondTo (secondTo),
    .rstPulse (sysRstReq)
  );
endmodule

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;
  logic       clk = 1'b0;
  logic       rstPorN = 1'b0;
  logic       rstSysN = 1'b0;
  logic       tickEn = 1'b0;
  logic       busWrEn = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       smiReq;
  logic       sysRstReq;

  int total = 0;
  int bad = 0;
  bit tickOn = 0;
  int divCnt = 0;
  bit done = 0;

  // reference model state
  int mCnt, mTmr, mHalt, mSmi, mReb, mFirst, mSecond, mArmed, mPulse;
  bit modelLive = 0;

  always #10 clk = ~clk;  // 50 MHz

  wdog_two_stage u_dut (
    .clk(clk), .rstPorN(rstPorN), .rstSysN(rstSysN), .tickEn(tickEn),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .smiReq(smiReq), .sysRstReq(sysRstReq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelSysReset();
    mCnt = 50; mTmr = 50; mHalt = 1; mSmi = 0; mReb = 0;
    mFirst = 0; mArmed = 0; mPulse = 0;
  endtask

  function automatic int expRead(input int a);
    case (a)
      0: return mCnt;
      1: return mTmr;
      4: return (mSecond << 1) | mFirst;
      8: return (mReb << 1) | mSmi;
      9: return mHalt << 3;
      default: return 0;
    endcase
  endfunction

  // tick prescaler stand-in: one strobe every 4 clocks
  always @(negedge clk) begin
    divCnt = (divCnt + 1) % 4;
    tickEn <= tickOn && (divCnt == 0);
  end

  // behavioural model, stepped on the same edge as the design
  always @(posedge clk) begin
    int oCnt, oTmr, oHalt, oReb, oArmed;
    bit firstNow, secNow;
    oCnt = mCnt; oTmr = mTmr; oHalt = mHalt; oReb = mReb; oArmed = mArmed;
    firstNow = 0; secNow = 0;
    modelLive = 1;
    if (!rstPorN) begin
      mSecond = 0;
      modelSysReset();
    end else if (!rstSysN) begin
      modelSysReset();
    end else begin
      mPulse = 0;
      if (busWrEn && busAddr == 4'h0 && busWrData == 8'h01) begin
        mCnt = oTmr & 63; mArmed = 0;
      end else if (!oHalt && tickEn) begin
        if (oCnt <= 1) begin
          mCnt = oTmr & 63;
          if (!oArmed) begin mArmed = 1; mFirst = 1; firstNow = 1; end
          else begin mArmed = 0; mSecond = 1; secNow = 1; mPulse = oReb; end
        end else mCnt = oCnt - 1;
      end
      if (busWrEn) begin
        case (busAddr)
          4'h1: mTmr = (int'(busWrData) & 8'hC0) |
                       (((int'(busWrData) & 63) >= 4) ? (int'(busWrData) & 63) : (oTmr & 63));
          4'h4: begin
            if (busWrData[0] && !firstNow) mFirst = 0;
            if (busWrData[1] && !secNow) mSecond = 0;
          end
          4'h8: begin mSmi = busWrData[0]; mReb = busWrData[1]; end
          4'h9: mHalt = busWrData[3];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #4;
    if (modelLive && !done) begin
      string tag;
      case (busAddr)
        4'h0: tag = "R2 live count";
        4'h1: tag = "R3 timer value";
        4'h4: tag = "R7 status";
        default: tag = "R4 control";
      endcase
      chk(int'(busRdData) == expRead(int'(busAddr)), tag, busRdData, expRead(int'(busAddr)));
      chk(int'(smiReq) == (mSmi & mFirst), "R5 smiReq", smiReq, mSmi & mFirst);
      chk(int'(sysRstReq) == mPulse, "R6 sysRstReq", sysRstReq, mPulse);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    busAddr = a;
    #2;
    v = busRdData;
  endtask

  task automatic rdChk(input logic [3:0] a, input int exp, input string tag);
    int v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired, run hung");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    int seen;
    repeat (3) @(negedge clk);
    rstPorN = 1; rstSysN = 1;

    // R1 reset values
    rdChk(4'h0, 50, "R1 count");
    rdChk(4'h1, 8'h32, "R1 timer");
    rdChk(4'h4, 0, "R1 status");
    rdChk(4'h8, 0, "R1 enables");
    rdChk(4'h9, 8'h08, "R1 halt");
    chk(smiReq == 0 && sysRstReq == 0, "R1 requests", {smiReq, sysRstReq}, 0);

    // R3 small counts ignored, upper bits kept
    wr(4'h1, 8'hC2); rdChk(4'h1, 8'hF2, "R3 count 2 ignored");
    wr(4'h1, 8'h03); rdChk(4'h1, 8'h32, "R3 count 3 ignored");
    wr(4'h1, 8'h04); rdChk(4'h1, 8'h04, "R3 count 4 boundary");
    wr(4'h1, 8'h3F); rdChk(4'h1, 8'h3F, "R3 count 63");
    wr(4'h1, 8'h08);

    // R2 reload key
    wr(4'h0, 8'h01); rdChk(4'h0, 8, "R2 key reload");
    wr(4'h1, 8'h0A);
    wr(4'h0, 8'h05); rdChk(4'h0, 8, "R2 non-key ignored");
    wr(4'h0, 8'h01); rdChk(4'h0, 10, "R2 reload 10");

    // R4 halt freezes
    tickOn = 1;
    repeat (40) @(negedge clk);
    rdChk(4'h0, 10, "R4 halted count");
    wr(4'h8, 8'h03);
    wr(4'h9, 8'h00);
    repeat (14) @(negedge clk);
    rd(4'h0, v);
    chk(v < 10 && v >= 4, "R4 counting", v, 7);

    // R5 first expiry
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin @(negedge clk); if (smiReq) seen = 1; end
    chk(seen == 1, "R5 first expiry smi", seen, 1);
    rdChk(4'h4, 1, "R5 status first");

    // R6 second expiry with reboot enabled
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin @(negedge clk); if (sysRstReq) seen = 1; end
    chk(seen == 1, "R6 reset pulse", seen, 1);
    rdChk(4'h4, 3, "R6 status both");

    // R8 system reset keeps second flag
    @(negedge clk); rstSysN = 0;
    repeat (2) @(negedge clk); rstSysN = 1;
    rdChk(4'h4, 2, "R8 second survives");
    rdChk(4'h9, 8'h08, "R8 halt restored");
    rdChk(4'h1, 8'h32, "R8 timer restored");
    rdChk(4'h8, 0, "R8 enables restored");

    // R7 write-one-to-clear
    wr(4'h4, 8'h01); rdChk(4'h4, 2, "R7 clear first only");
    wr(4'h4, 8'h02); rdChk(4'h4, 0, "R7 clear second");

    // R6 reboot disabled: no reset request
    wr(4'h1, 8'h04);
    wr(4'h8, 8'h00);
    wr(4'h0, 8'h01);
    wr(4'h9, 8'h00);
    seen = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (sysRstReq) seen++; end
    wr(4'h9, 8'h08);
    chk(seen == 0, "R6 gated by reboot enable", seen, 0);
    rd(4'h4, v);
    chk((v & 2) == 2, "R6 second flag without reset", v, 2);
    chk(smiReq == 0, "R5 smi gated off", smiReq, 0);

    // R7 partial clear, then R8 power-on clears second
    wr(4'h4, 8'h01);
    rdChk(4'h4, 2, "R7 bit1 kept");
    @(negedge clk); rstPorN = 0;
    repeat (2) @(negedge clk); rstPorN = 1;
    rdChk(4'h4, 0, "R8 power-on clears");

    // R9 reloads keep it in the first stage
    wr(4'h1, 8'h04);
    wr(4'h0, 8'h01);
    wr(4'h9, 8'h00);
    for (int i = 0; i < 25; i++) begin
      wr(4'h0, 8'h01);
      repeat (5) @(negedge clk);
    end
    wr(4'h9, 8'h08);
    rdChk(4'h4, 0, "R9 no expiry with reloads");

    // R9 reload after first expiry re-arms first stage
    wr(4'h9, 8'h00);
    seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      rd(4'h4, v); if (v == 1) seen = 1;
    end
    wr(4'h0, 8'h01);
    wr(4'h4, 8'h01);
    repeat (20) @(negedge clk);
    wr(4'h9, 8'h08);
    rd(4'h4, v);
    chk(seen == 1 && (v & 2) == 0, "R9 re-armed first stage", v, 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule